// File: doc/BRIEF.md
# DAC Code Conditioning and Output Control

This block sits between the waveform sources of a 12-bit converter and its analog ladder. On each update strobe it takes a 12-bit channel value from one of three places: the current table word, a data-mode accumulator, or a one-deep firmware sample slot. It holds that value and presents it as an offset-binary level code. Signed two's-complement values are re-biased by adding half scale, and a bottom-select bit lifts code zero to one LSB.

The data-mode accumulator is loaded from the table word. After that it is stepped up or down by a programmable step and saturates at the limits of the selected format. Each update also checks the taken value against a programmable window and reports the result as a one-cycle range event.

A registered output-state code resolves the enable, drive-mode and disabled-mode settings into tri-state, a low rail, the reference rail, or drive-the-code.

The firmware slot is written through a valid/ready pair. It accepts a sample only while it is free, so `fw_ready` is low from an accepted write until an update of the firmware source takes the sample. A writer holding `fw_valid` high simply waits. Data never changes the slot while `fw_ready` is low.

Top module: `dac_code_cond`

## Requirements
- R1: After reset, `level_code` reflects a held value of 0, `out_state` is 0 (tri-state), `range_evt` and `fw_empty` are 0, `fw_ready` is 1, and the accumulator holds 0.
- R2: `level_code` (13 bits) equals the held value when `cfg_signed`=0, or (held value + 0x800) mod 4096 when `cfg_signed`=1. In both cases 1 is added when `cfg_bottom`=1. It follows format and bottom changes at once, with no clock.
- R3: With `acc_load`=1 the accumulator takes `lut_word` on the next edge. `acc_load` wins over `acc_inc`/`acc_dec` in the same cycle.
- R4: `acc_inc` adds `step` and `acc_dec` subtracts `step`. When both are high in the same cycle (without load), the accumulator is unchanged.
- R5: For unsigned format (`cfg_signed`=0), accumulator steps saturate at 0x000 and 0xFFF.
- R6: For signed format, accumulator steps saturate at 0x800 (most negative) and 0x7FF (most positive), compared as signed numbers.
- R7: On an edge with `upd`=1, the held value becomes the source picked by `src_sel`: 0 = `lut_word`, 1 = accumulator, 2 = firmware slot (unchanged if the slot is empty), 3 = unchanged. Without `upd` the held value does not change.
- R8: `out_state`, one edge after the inputs, is computed as follows:
  - `cfg_enable`=0 gives 0 (tri-state).
  - Otherwise `cfg_drive_mode`=2 gives 3 (drive code).
  - Otherwise, for drive modes 0, 1 and 3: `cfg_dis_drive`=0 gives 0, and `cfg_dis_drive`=1 gives 2 (reference) if `cfg_bottom`=1, or 1 (low rail) if `cfg_bottom`=0.
- R9: `range_mode` selects the window test. The value and both limits are compared in the current format, as signed numbers when `cfg_signed`=1. The codes are:
  - 1: inside, lo ≤ v ≤ hi.
  - 2: outside, v < lo or v > hi.
  - 3: below, v < lo.
  - 4: above, v > hi.
  - 0, 5, 6, 7: off.
- R10: `range_evt` is a one-cycle pulse, registered on the edge where `upd`=1 and the newly taken value meets the condition. It is 0 on every edge without `upd`.
- R11: A firmware write is accepted when `fw_valid` and `fw_ready` are both 1. After acceptance `fw_ready` is 0 until an update of source 2 takes the sample. At that point `fw_ready` returns to 1 and `fw_empty` rises. `fw_empty` clears on the next accepted write.
- R12: Source 0 passes `lut_word` through unchanged to the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_signed | input | 1 | 1 = values are two's complement |
| cfg_bottom | input | 1 | Bottom select: code zero maps to one LSB; picks reference rail in disabled drive |
| cfg_enable | input | 1 | Converter enable |
| cfg_drive_mode | input | 2 | 0 high-impedance, 1 reference, 2 active, 3 as 0 |
| cfg_dis_drive | input | 1 | Disabled-mode behaviour: 0 tri-state, 1 drive a rail |
| range_mode | input | 3 | Window test select (R9) |
| range_lo | input | 12 | Lower limit, in current format |
| range_hi | input | 12 | Upper limit, in current format |
| src_sel | input | 2 | Update source select (R7) |
| lut_word | input | 12 | Current table word |
| step | input | 12 | Accumulator step |
| acc_load | input | 1 | Load accumulator from `lut_word` |
| acc_inc | input | 1 | Step accumulator up |
| acc_dec | input | 1 | Step accumulator down |
| upd | input | 1 | Update strobe |
| fw_valid | input | 1 | Firmware sample valid |
| fw_data | input | 12 | Firmware sample |
| fw_ready | output | 1 | Firmware slot can accept |
| level_code | output | 13 | Offset-binary level, 0..4096 |
| out_state | output | 2 | 0 tri-state, 1 low rail, 2 reference, 3 drive code |
| range_evt | output | 1 | Range condition pulse |
| fw_empty | output | 1 | Firmware sample taken, none pending |

## Verification
The held value changes on the edge that samples `upd`, so `level_code` is checked one settle delay after that edge. Format and bottom changes are combinational, so they are checked a short delay after the configuration moves, with no clock in between. `out_state` and `range_evt` are registers fed from inputs present at the edge, so both are sampled just after the edge that follows the stimulus. Every `range_evt` check is paired with a check one edge later that the pulse has dropped. Accumulator steps show on the edge after `acc_inc`/`acc_dec`, and the bench sees them only through a separate update cycle with source 1. Each step result is therefore read two edges after the step pulse.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    OUT_TRI  = 2'd0,
    OUT_LOW  = 2'd1,
    OUT_REF  = 2'd2,
    OUT_CODE = 2'd3
  } out_state_e;

  typedef enum logic [1:0] {
    DRV_HIZ    = 2'd0,
    DRV_REFPIN = 2'd1,
    DRV_ACTIVE = 2'd2,
    DRV_SPARE  = 2'd3
  } drive_mode_e;

  typedef enum logic [1:0] {
    SRC_LUT  = 2'd0,
    SRC_ACC  = 2'd1,
    SRC_FW   = 2'd2,
    SRC_HOLD = 2'd3
  } src_sel_e;

  localparam logic [2:0] RNG_INSIDE  = 3'd1;
  localparam logic [2:0] RNG_OUTSIDE = 3'd2;
  localparam logic [2:0] RNG_BELOW   = 3'd3;
  localparam logic [2:0] RNG_ABOVE   = 3'd4;
endpackage

// File: rtl/dcc_accum.sv
module dcc_accum #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_signed,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         inc,
  input  logic         dec,
  input  logic [W-1:0] step,
  output logic [W-1:0] acc_o
);
  localparam logic [W-1:0] MAXC = {W{1'b1}};
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc_q, bias, off, up_off, dn_off, acc_d;
  logic [W:0]   sum, diff;

  // Work in offset binary so both formats saturate with one unsigned compare.
  assign bias   = fmt_signed ? HALF : '0;
  assign off    = acc_q ^ bias;
  assign sum    = {1'b0, off} + {1'b0, step};
  assign diff   = {1'b0, off} - {1'b0, step};
  assign up_off = sum[W]  ? MAXC : sum[W-1:0];
  assign dn_off = diff[W] ? '0   : diff[W-1:0];

  always_comb begin
    acc_d = acc_q;
    if (load)             acc_d = load_word;
    else if (inc && !dec) acc_d = up_off ^ bias;
    else if (dec && !inc) acc_d = dn_off ^ bias;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dcc_fwslot.sv
module dcc_fwslot #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         take,
  output logic         hit_o,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  logic         full_q, empty_q;
  logic [W-1:0] data_q;
  logic         accept;

  assign wr_ready = !full_q;
  assign accept   = wr_valid && !full_q;
  assign hit_o    = take && full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (accept) begin
        full_q  <= 1'b1;
        empty_q <= 1'b0;
        data_q  <= wr_data;
      end else if (hit_o) begin
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/dcc_range.sv
module dcc_range #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         fmt_signed,
  input  logic [W-1:0] val,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [2:0]   mode,
  output logic         evt_o
);
  import dcc_pkg::*;
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] bias, v_u, lo_u, hi_u;
  logic         below, above, hit;
  logic         evt_q;

  // Re-biasing turns a signed compare into an unsigned one.
  assign bias  = fmt_signed ? HALF : '0;
  assign v_u   = val ^ bias;
  assign lo_u  = lo ^ bias;
  assign hi_u  = hi ^ bias;
  assign below = v_u < lo_u;
  assign above = v_u > hi_u;

  always_comb begin
    case (mode)
      RNG_INSIDE:  hit = !below && !above;
      RNG_OUTSIDE: hit = below || above;
      RNG_BELOW:   hit = below;
      RNG_ABOVE:   hit = above;
      default:     hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= fire && hit;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/dcc_drive.sv
module dcc_drive (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] drive_mode,
  input  logic       dis_drive,
  input  logic       bottom,
  output logic [1:0] state_o
);
  import dcc_pkg::*;
  out_state_e st_d, st_q;

  always_comb begin
    if (!enable)                                   st_d = OUT_TRI;
    else if (drive_mode_e'(drive_mode) == DRV_ACTIVE) st_d = OUT_CODE;
    else if (!dis_drive)                           st_d = OUT_TRI;
    else if (bottom)                               st_d = OUT_REF;
    else                                           st_d = OUT_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= OUT_TRI;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/dac_code_cond.sv
module dac_code_cond #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_signed,
  input  logic         cfg_bottom,
  input  logic         cfg_enable,
  input  logic [1:0]   cfg_drive_mode,
  input  logic         cfg_dis_drive,
  input  logic [2:0]   range_mode,
  input  logic [W-1:0] range_lo,
  input  logic [W-1:0] range_hi,
  input  logic [1:0]   src_sel,
  input  logic [W-1:0] lut_word,
  input  logic [W-1:0] step,
  input  logic         acc_load,
  input  logic         acc_inc,
  input  logic         acc_dec,
  input  logic         upd,
  input  logic         fw_valid,
  input  logic [W-1:0] fw_data,
  output logic         fw_ready,
  output logic [W:0]   level_code,
  output logic [1:0]   out_state,
  output logic         range_evt,
  output logic         fw_empty
);
  import dcc_pkg::*;
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] acc_q, fw_word, val_q, val_d;
  logic         fw_hit, fw_take;

  dcc_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .fmt_signed(cfg_signed),
    .load(acc_load), .load_word(lut_word),
    .inc(acc_inc), .dec(acc_dec), .step(step), .acc_o(acc_q)
  );

  assign fw_take = upd && (src_sel_e'(src_sel) == SRC_FW);

  dcc_fwslot #(.W(W)) u_fw (
    .clk(clk), .rst_n(rst_n), .wr_valid(fw_valid), .wr_data(fw_data),
    .wr_ready(fw_ready), .take(fw_take), .hit_o(fw_hit),
    .data_o(fw_word), .empty_o(fw_empty)
  );

  always_comb begin
    val_d = val_q;
    if (upd) begin
      case (src_sel_e'(src_sel))
        SRC_LUT: val_d = lut_word;
        SRC_ACC: val_d = acc_q;
        SRC_FW:  val_d = fw_hit ? fw_word : val_q;
        default: val_d = val_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  dcc_range #(.W(W)) u_range (
    .clk(clk), .rst_n(rst_n), .fire(upd), .fmt_signed(cfg_signed),
    .val(val_d), .lo(range_lo), .hi(range_hi), .mode(range_mode),
    .evt_o(range_evt)
  );

  dcc_drive u_drive (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
    .drive_mode(cfg_drive_mode), .dis_drive(cfg_dis_drive),
    .bottom(cfg_bottom), .state_o(out_state)
  );

  assign level_code = {1'b0, val_q ^ (cfg_signed ? HALF : '0)}
                      + {{W{1'b0}}, cfg_bottom};
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_enable,
  input logic [1:0]   cfg_drive_mode,
  input logic         cfg_bottom,
  input logic         acc_load,
  input logic         acc_inc,
  input logic         acc_dec,
  input logic         upd,
  input logic         fw_valid,
  input logic         fw_ready,
  input logic         fw_empty,
  input logic         range_evt,
  input logic [1:0]   out_state,
  input logic [W:0]   level_code,
  input logic [W-1:0] val_q,
  input logic [W-1:0] acc_q
);
  AST_TRI_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> out_state == 2'd0); // R8
  AST_ACTIVE_DRIVES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_drive_mode == 2'd2) |=> out_state == 2'd3); // R8
  AST_EVT_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> !range_evt); // R10
  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(val_q)); // R7
  AST_BOTH_STEPS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_inc && acc_dec && !acc_load) |=> $stable(acc_q)); // R4
  AST_FW_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_valid && fw_ready) |=> (!fw_ready && !fw_empty)); // R11
  AST_EMPTY_MEANS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fw_empty |-> fw_ready); // R11
  AST_BOTTOM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bottom |-> level_code != '0); // R2
endmodule

bind dac_code_cond dcc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
  .cfg_drive_mode(cfg_drive_mode), .cfg_bottom(cfg_bottom),
  .acc_load(acc_load), .acc_inc(acc_inc), .acc_dec(acc_dec), .upd(upd),
  .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_empty(fw_empty),
  .range_evt(range_evt), .out_state(out_state), .level_code(level_code),
  .val_q(val_q), .acc_q(acc_q)
);

// File: tb/tb_dac_code_cond.sv
module tb_dac_code_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_signed = 0, cfg_bottom = 0, cfg_enable = 0, cfg_dis_drive = 0;
  logic [1:0]  cfg_drive_mode = 0, src_sel = 0;
  logic [2:0]  range_mode = 0;
  logic [11:0] range_lo = 0, range_hi = 0, lut_word = 0, step = 0, fw_data = 0;
  logic        acc_load = 0, acc_inc = 0, acc_dec = 0, upd = 0, fw_valid = 0;
  logic        fw_ready, range_evt, fw_empty;
  logic [12:0] level_code;
  logic [1:0]  out_state;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dac_code_cond dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int sval(input int v, input bit fmt);
    return (fmt && v >= 2048) ? v - 4096 : v;
  endfunction

  function automatic int step_model(input int acc, input int st, input bit up, input bit fmt);
    int s = sval(acc, fmt);
    int lo = fmt ? -2048 : 0;
    int hi = fmt ? 2047 : 4095;
    int n = up ? s + st : s - st;
    if (n > hi) n = hi;
    if (n < lo) n = lo;
    return n < 0 ? n + 4096 : n;
  endfunction

  task automatic take(input logic [1:0] s);
    src_sel = s; upd = 1; tick(); upd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ref_acc, e, lo, hi;
    tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    chk(level_code == 0, "R1 level", level_code, 0);
    chk(out_state == 0, "R1 out_state", out_state, 0);
    chk(range_evt == 0, "R1 range_evt", range_evt, 0);
    chk(fw_empty == 0, "R1 fw_empty", fw_empty, 0);
    chk(fw_ready == 1, "R1 fw_ready", fw_ready, 1);
    take(2'd1);
    chk(level_code == 0, "R1 accumulator", level_code, 0);

    // R12 / R2: every code through source 0, all format/bottom combinations
    for (int v = 0; v < 4096; v++) begin
      cfg_signed = 0; cfg_bottom = 0; lut_word = 12'(v);
      take(2'd0);
      chk(level_code == 13'(v), "R12 lut pass", level_code, v);
      for (int f = 0; f < 2; f++)
        for (int b = 0; b < 2; b++) begin
          cfg_signed = f[0]; cfg_bottom = b[0]; #1;
          e = (f ? (v + 2048) % 4096 : v) + b;
          chk(level_code == 13'(e), "R2 format/bottom", level_code, e);
        end
    end
    cfg_signed = 0; cfg_bottom = 0;

    // R8 output state table, every combination
    for (int en = 0; en < 2; en++)
      for (int dm = 0; dm < 4; dm++)
        for (int dd = 0; dd < 2; dd++)
          for (int b = 0; b < 2; b++) begin
            cfg_enable = en[0]; cfg_drive_mode = 2'(dm);
            cfg_dis_drive = dd[0]; cfg_bottom = b[0];
            tick();
            if (!en) e = 0;
            else if (dm == 2) e = 3;
            else if (!dd) e = 0;
            else e = b ? 2 : 1;
            chk(out_state == 2'(e), "R8 out_state", out_state, e);
          end
    cfg_bottom = 0; cfg_enable = 0;

    // R3..R6 accumulator sweeps
    for (int f = 0; f < 2; f++)
      for (int si = 0; si < 4; si++) begin
        cfg_signed = f[0];
        case (si)
          0: step = 12'd1;
          1: step = 12'd5;
          2: step = 12'h300;
          default: step = 12'hFFF;
        endcase
        lut_word = f ? 12'h7F0 : 12'hFF0;
        ref_acc = int'(lut_word);
        acc_load = 1; acc_inc = 1; tick(); acc_load = 0; acc_inc = 0;
        take(2'd1);
        e = (ref_acc + (f ? 2048 : 0)) % 4096;
        chk(level_code == 13'(e), "R3 load", level_code, e);
        for (int k = 0; k < 40; k++) begin
          if (k == 20) begin
            acc_inc = 1; acc_dec = 1; tick(); acc_inc = 0; acc_dec = 0;
            take(2'd1);
            e = (ref_acc + (f ? 2048 : 0)) % 4096;
            chk(level_code == 13'(e), "R4 both ignored", level_code, e);
          end
          if (k < 12) acc_inc = 1; else acc_dec = 1;
          tick(); acc_inc = 0; acc_dec = 0;
          ref_acc = step_model(ref_acc, int'(step), k < 12, f[0]);
          take(2'd1);
          e = (ref_acc + (f ? 2048 : 0)) % 4096;
          chk(level_code == 13'(e), f ? "R6 signed step" : "R5 unsigned step",
              level_code, e);
        end
      end

    // R9 / R10 range conditions
    for (int f = 0; f < 2; f++) begin
      cfg_signed = f[0];
      range_lo = f ? 12'hF00 : 12'h100;
      range_hi = f ? 12'h200 : 12'h600;
      lo = sval(int'(range_lo), f[0]);
      hi = sval(int'(range_hi), f[0]);
      for (int m = 0; m < 6; m++) begin
        range_mode = 3'(m);
        for (int k = 0; k < 320; k++) begin
          int v, s;
          bit ex;
          case (k)
            316: v = int'(range_lo) - 1;
            317: v = int'(range_lo);
            318: v = int'(range_hi);
            319: v = int'(range_hi) + 1;
            default: v = k * 13;
          endcase
          v = v & 12'hFFF;
          s = sval(v, f[0]);
          case (m)
            1: ex = (s >= lo) && (s <= hi);
            2: ex = (s < lo) || (s > hi);
            3: ex = s < lo;
            4: ex = s > hi;
            default: ex = 0;
          endcase
          lut_word = 12'(v);
          take(2'd0);
          chk(range_evt == ex, "R9 range condition", range_evt, ex);
          tick();
          chk(range_evt == 0, "R10 pulse width", range_evt, 0);
        end
      end
    end
    range_mode = 0; cfg_signed = 0;

    // R11 firmware slot, R7 hold source
    chk(fw_ready == 1, "R11 ready idle", fw_ready, 1);
    fw_data = 12'hABC; fw_valid = 1; tick(); fw_valid = 0;
    chk(fw_ready == 0, "R11 ready after write", fw_ready, 0);
    chk(fw_empty == 0, "R11 not empty after write", fw_empty, 0);
    fw_data = 12'h123; fw_valid = 1; tick(); fw_valid = 0;
    take(2'd2);
    chk(level_code == 13'hABC, "R11 first sample kept", level_code, 13'hABC);
    chk(fw_empty == 1, "R11 empty after take", fw_empty, 1);
    chk(fw_ready == 1, "R11 ready after take", fw_ready, 1);
    take(2'd2);
    chk(level_code == 13'hABC, "R7 empty slot holds", level_code, 13'hABC);
    chk(fw_empty == 1, "R11 empty stays", fw_empty, 1);
    fw_data = 12'h055; fw_valid = 1; tick(); fw_valid = 0;
    chk(fw_empty == 0, "R11 write clears empty", fw_empty, 0);
    take(2'd2);
    chk(level_code == 13'h055, "R11 second sample", level_code, 13'h055);
    lut_word = 12'h777;
    take(2'd3);
    chk(level_code == 13'h055, "R7 hold source", level_code, 13'h055);
    src_sel = 0; tick(); tick();
    chk(level_code == 13'h055, "R7 no update holds", level_code, 13'h055);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule